// File: doc/BRIEF.md
# Bank-Switched Dual-Port Memory with Mailboxes

This block gives two independent requesters, port A and port B, shared access to a word store that is split into four separate banks. Each port carries its own enables, bank select, word address, write data and read data, so both ports can work at once as long as they sit in different banks. A 2-bit bank field on each port routes its access into one bank, where a word address picks the location. At full size each bank holds 16K words of 16 bits (`ADDR_W = 14`). The smaller default keeps elaboration light.

When both ports pick the same bank in the same cycle, port A wins. Port B's access is dropped, and port B sees a busy flag in the cycle its read data would have arrived. Two message registers let the ports talk to each other, one for each direction. They sit in a separate space chosen by a per-port message-select input. A write to a message register raises an interrupt at the other port, and that port clears the interrupt by reading the message. A port responds only while both of its enables are asserted: its active-low enable is low and its active-high enable is high.

The block is fully synchronous. It has an active-high synchronous reset, registered read paths and one memory per bank written so that block RAM can be inferred.

Top module: `dpbank_top`

## Requirements
- R1: After reset both interrupt outputs are 0, `pb_busy` is 0, both read data outputs are 0, and reading either message register returns 0.
- R2: A port is active only while `*_sel_n` = 0 and `*_sel` = 1. An inactive port writes no bank, changes no message register or interrupt, and shows 0 on its read data in the next cycle.
- R3: The bank field value n (0 to 3) routes an access into bank n. The same word address in different banks refers to separate storage.
- R4: A read issued on a clock edge shows its data on `*_rdata` until the next edge. After an edge with a write, no request or an inactive port, `*_rdata` is 0.
- R5: A bank write (`*_msg` = 0, `*_we` = 1) stores `*_wdata` at the chosen bank and address on the edge where it is presented, unless it is blocked.
- R6: If both ports make bank accesses to the same bank in the same cycle, port A's access completes. Port B's write is discarded, and in the following cycle `pb_busy` is 1 and `pb_rdata` is 0.
- R7: Bank accesses by the two ports to different banks in the same cycle both complete, and `pb_busy` stays 0.
- R8: A message write (`*_msg` = 1, `*_we` = 1) loads the port's outgoing message register and sets the other port's interrupt from the next cycle. The bank field and address are ignored, and no bank contents change.
- R9: A message read (`*_msg` = 1, `*_we` = 0) returns the incoming message register in the next cycle and clears the reading port's own interrupt. If the other port writes that register in the same cycle, the read returns the old contents and the interrupt stays set.
- R10: Each message register keeps its value until its owner writes it again. The two directions do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_sel_n | input | 1 | Port A enable, active low |
| pa_sel | input | 1 | Port A enable, active high |
| pa_msg | input | 1 | Port A targets the message registers instead of a bank |
| pa_we | input | 1 | Port A write request |
| pa_bank | input | BANK_W | Port A bank field |
| pa_addr | input | ADDR_W | Port A word address in the bank |
| pa_wdata | input | DATA_W | Port A write data |
| pa_rdata | output | DATA_W | Port A read data, one cycle after the request |
| pa_irq | output | 1 | Port A message-waiting interrupt |
| pb_sel_n | input | 1 | Port B enable, active low |
| pb_sel | input | 1 | Port B enable, active high |
| pb_msg | input | 1 | Port B targets the message registers instead of a bank |
| pb_we | input | 1 | Port B write request |
| pb_bank | input | BANK_W | Port B bank field |
| pb_addr | input | ADDR_W | Port B word address in the bank |
| pb_wdata | input | DATA_W | Port B write data |
| pb_rdata | output | DATA_W | Port B read data, one cycle after the request |
| pb_irq | output | 1 | Port B message-waiting interrupt |
| pb_busy | output | 1 | Port B's previous access was blocked by port A |

## Verification
The bench builds the block with `ADDR_W = 6`, `DATA_W = 16` and `BANK_W = 2`. That keeps all four banks and their top address (63) within reach of short directed sequences. With this build the same address can be written in every bank and read back from the other port. Same-bank and different-bank collisions can be staged in adjacent cycles. The message race, where one side reads while the other writes in the same cycle, can be set up deliberately.

// File: rtl/dpbank_pkg.sv
package dpbank_pkg;
  // A port responds only with its low enable low and high enable high.
  function automatic logic port_on(input logic en_n, input logic en);
    return (!en_n) && en;
  endfunction
endpackage

// File: rtl/dpbank_ram.sv
module dpbank_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    dout      <= mem[addr];
    end
  end
endmodule

// File: rtl/dpbank_route.sv
module dpbank_route #(
  parameter int BANK_W = 2
) (
  input  logic              a_req,
  input  logic [BANK_W-1:0] a_bank,
  input  logic              b_req,
  input  logic [BANK_W-1:0] b_bank,
  output logic              b_block,
  output logic [(1<<BANK_W)-1:0] a_hit,
  output logic [(1<<BANK_W)-1:0] b_hit
);
  localparam int BANKS = 1 << BANK_W;

  assign b_block = a_req && b_req && (a_bank == b_bank);

  for (genvar i = 0; i < BANKS; i++) begin : g_hit
    assign a_hit[i] = a_req && (a_bank == BANK_W'(i));
    assign b_hit[i] = b_req && !b_block && (b_bank == BANK_W'(i));
  end
endmodule

// File: rtl/dpbank_mbox.sv
module dpbank_mbox #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] box_ab,
  output logic [DATA_W-1:0] box_ba,
  output logic              irq_a,
  output logic              irq_b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      box_ab <= '0;
      box_ba <= '0;
      irq_a  <= 1'b0;
      irq_b  <= 1'b0;
    end else begin
      if (a_wr) box_ab <= a_wdata;
      if (b_wr) box_ba <= b_wdata;
      // a new message outranks a clearing read in the same cycle
      if (a_wr)      irq_b <= 1'b1;
      else if (b_rd) irq_b <= 1'b0;
      if (b_wr)      irq_a <= 1'b1;
      else if (a_rd) irq_a <= 1'b0;
    end
  end

  p_set_irq_b_r8: assert property (@(posedge clk) disable iff (rst)
    a_wr |=> irq_b);
  p_set_irq_a_r8: assert property (@(posedge clk) disable iff (rst)
    b_wr |=> irq_a);
  p_clear_irq_a_r9: assert property (@(posedge clk) disable iff (rst)
    (a_rd && !b_wr) |=> !irq_a);
  p_hold_ab_r10: assert property (@(posedge clk) disable iff (rst)
    !a_wr |=> $stable(box_ab));
  p_hold_ba_r10: assert property (@(posedge clk) disable iff (rst)
    !b_wr |=> $stable(box_ba));
endmodule

// File: rtl/dpbank_top.sv
module dpbank_top #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pa_sel_n,
  input  logic              pa_sel,
  input  logic              pa_msg,
  input  logic              pa_we,
  input  logic [BANK_W-1:0] pa_bank,
  input  logic [ADDR_W-1:0] pa_addr,
  input  logic [DATA_W-1:0] pa_wdata,
  output logic [DATA_W-1:0] pa_rdata,
  output logic              pa_irq,
  input  logic              pb_sel_n,
  input  logic              pb_sel,
  input  logic              pb_msg,
  input  logic              pb_we,
  input  logic [BANK_W-1:0] pb_bank,
  input  logic [ADDR_W-1:0] pb_addr,
  input  logic [DATA_W-1:0] pb_wdata,
  output logic [DATA_W-1:0] pb_rdata,
  output logic              pb_irq,
  output logic              pb_busy
);
  import dpbank_pkg::*;

  localparam int BANKS = 1 << BANK_W;

  logic pa_act, pb_act, pa_bk, pb_bk, pa_mb, pb_mb, b_block;
  logic [BANKS-1:0] a_hit, b_hit;
  logic [DATA_W-1:0] bank_q [BANKS];
  logic [DATA_W-1:0] box_ab, box_ba;

  assign pa_act = port_on(pa_sel_n, pa_sel);
  assign pb_act = port_on(pb_sel_n, pb_sel);
  assign pa_bk  = pa_act && !pa_msg;
  assign pb_bk  = pb_act && !pb_msg;
  assign pa_mb  = pa_act && pa_msg;
  assign pb_mb  = pb_act && pb_msg;

  dpbank_route #(.BANK_W(BANK_W)) u_route (
    .a_req(pa_bk), .a_bank(pa_bank),
    .b_req(pb_bk), .b_bank(pb_bank),
    .b_block(b_block), .a_hit(a_hit), .b_hit(b_hit)
  );

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    logic              en, we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wd;
    assign en   = a_hit[i] || b_hit[i];
    assign we   = a_hit[i] ? pa_we    : pb_we;
    assign addr = a_hit[i] ? pa_addr  : pb_addr;
    assign wd   = a_hit[i] ? pa_wdata : pb_wdata;
    dpbank_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk(clk), .en(en), .we(we), .addr(addr), .wdata(wd), .dout(bank_q[i])
    );
  end

  dpbank_mbox #(.DATA_W(DATA_W)) u_mbox (
    .clk(clk), .rst(rst),
    .a_wr(pa_mb && pa_we), .a_rd(pa_mb && !pa_we), .a_wdata(pa_wdata),
    .b_wr(pb_mb && pb_we), .b_rd(pb_mb && !pb_we), .b_wdata(pb_wdata),
    .box_ab(box_ab), .box_ba(box_ba), .irq_a(pa_irq), .irq_b(pb_irq)
  );

  // Read-return tracking, one cycle behind the request.
  logic              pa_vld_q, pb_vld_q, pa_mbx_q, pb_mbx_q;
  logic [BANK_W-1:0] pa_bank_q, pb_bank_q;
  logic [DATA_W-1:0] pa_mq, pb_mq;

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_vld_q  <= 1'b0;
      pb_vld_q  <= 1'b0;
      pa_mbx_q  <= 1'b0;
      pb_mbx_q  <= 1'b0;
      pa_bank_q <= '0;
      pb_bank_q <= '0;
      pa_mq     <= '0;
      pb_mq     <= '0;
      pb_busy   <= 1'b0;
    end else begin
      pa_vld_q  <= pa_act && !pa_we;
      pb_vld_q  <= pb_act && !pb_we && !b_block;
      pa_mbx_q  <= pa_msg;
      pb_mbx_q  <= pb_msg;
      pa_bank_q <= pa_bank;
      pb_bank_q <= pb_bank;
      pa_mq     <= box_ba;
      pb_mq     <= box_ab;
      pb_busy   <= b_block;
    end
  end

  assign pa_rdata = !pa_vld_q ? '0 : (pa_mbx_q ? pa_mq : bank_q[pa_bank_q]);
  assign pb_rdata = !pb_vld_q ? '0 : (pb_mbx_q ? pb_mq : bank_q[pb_bank_q]);

  p_conflict_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (pa_bk && pb_bk && pa_bank == pb_bank) |=> pb_busy);
  p_busy_zero_r6: assert property (@(posedge clk) disable iff (rst)
    pb_busy |-> (pb_rdata == '0));
  p_split_free_r7: assert property (@(posedge clk) disable iff (rst)
    (pa_bk && pb_bk && pa_bank != pb_bank) |=> !pb_busy);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (pa_sel_n || !pa_sel) |=> (pa_rdata == '0));
  p_write_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (pb_act && pb_we) |=> (pb_rdata == '0));
endmodule

// File: tb/tb_dpbank_top.sv
module tb_dpbank_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int BANK_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pa_sel_n, pa_sel, pa_msg, pa_we, pb_sel_n, pb_sel, pb_msg, pb_we;
  logic [BANK_W-1:0] pa_bank, pb_bank;
  logic [ADDR_W-1:0] pa_addr, pb_addr;
  logic [DATA_W-1:0] pa_wdata, pb_wdata, pa_rdata, pb_rdata;
  logic pa_irq, pb_irq, pb_busy;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dpbank_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) dut (
    .clk(clk), .rst(rst),
    .pa_sel_n(pa_sel_n), .pa_sel(pa_sel), .pa_msg(pa_msg), .pa_we(pa_we),
    .pa_bank(pa_bank), .pa_addr(pa_addr), .pa_wdata(pa_wdata),
    .pa_rdata(pa_rdata), .pa_irq(pa_irq),
    .pb_sel_n(pb_sel_n), .pb_sel(pb_sel), .pb_msg(pb_msg), .pb_we(pb_we),
    .pb_bank(pb_bank), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
    .pb_rdata(pb_rdata), .pb_irq(pb_irq), .pb_busy(pb_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    pa_sel_n = 1'b1; pa_sel = 1'b0; pa_msg = 1'b0; pa_we = 1'b0;
    pa_bank = '0; pa_addr = '0; pa_wdata = '0;
    pb_sel_n = 1'b1; pb_sel = 1'b0; pb_msg = 1'b0; pb_we = 1'b0;
    pb_bank = '0; pb_addr = '0; pb_wdata = '0;
  endtask

  task automatic drv_a(input logic msg, input logic we, input int bank,
                       input int addr, input logic [15:0] d);
    pa_sel_n = 1'b0; pa_sel = 1'b1; pa_msg = msg; pa_we = we;
    pa_bank = BANK_W'(bank); pa_addr = ADDR_W'(addr); pa_wdata = d;
  endtask

  task automatic drv_b(input logic msg, input logic we, input int bank,
                       input int addr, input logic [15:0] d);
    pb_sel_n = 1'b0; pb_sel = 1'b1; pb_msg = msg; pb_we = we;
    pb_bank = BANK_W'(bank); pb_addr = ADDR_W'(addr); pb_wdata = d;
  endtask

  task automatic t_reset();
    idle(); rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    chk("R1 pa_irq", pa_irq, 0);
    chk("R1 pb_irq", pb_irq, 0);
    chk("R1 pb_busy", pb_busy, 0);
    chk("R1 pa_rdata", pa_rdata, 0);
    // message register contents after reset, read without disturbing irqs
    drv_a(1, 0, 0, 0, 0); drv_b(1, 0, 0, 0, 0); step(); idle();
    chk("R1 A message", pa_rdata, 0);
    chk("R1 B message", pb_rdata, 0);
  endtask

  task automatic t_rw();
    drv_a(0, 1, 1, 3, 16'h1234); step(); idle();
    chk("R4 write returns 0", pa_rdata, 0);
    drv_a(0, 0, 1, 3, 0); step(); idle();
    chk("R5 read back", pa_rdata, 16'h1234);
    step();
    chk("R4 idle returns 0", pa_rdata, 0);
  endtask

  task automatic t_banks();
    for (int i = 0; i < 4; i++) begin
      drv_a(0, 1, i, 7, 16'hA000 + 16'(i)); step();
    end
    idle();
    for (int i = 0; i < 4; i++) begin
      drv_b(0, 0, i, 7, 0); step();
      chk("R3 bank select", pb_rdata, 16'hA000 + 32'(i));
    end
    drv_b(0, 1, 2, 63, 16'h6363); step();
    drv_b(0, 0, 0, 0, 0); drv_a(0, 0, 2, 63, 0); step(); idle();
    chk("R3 top address", pa_rdata, 16'h6363);
  endtask

  task automatic t_enables();
    drv_a(0, 1, 0, 9, 16'h0101); step();
    drv_a(0, 1, 0, 9, 16'hFFFF); pa_sel_n = 1'b1; step();
    drv_a(0, 1, 0, 9, 16'hEEEE); pa_sel = 1'b0; step();
    drv_a(0, 0, 0, 9, 0); pa_sel_n = 1'b1; step();
    chk("R2 inactive read returns 0", pa_rdata, 0);
    drv_a(1, 1, 0, 0, 16'h5A5A); pa_sel = 1'b0; step();
    chk("R2 inactive message write", pb_irq, 0);
    drv_a(0, 0, 0, 9, 0); step(); idle();
    chk("R2 inactive writes dropped", pa_rdata, 16'h0101);
  endtask

  task automatic t_conflict();
    drv_a(0, 1, 3, 4, 16'h5555); step();
    drv_a(0, 0, 3, 4, 0); drv_b(0, 1, 3, 4, 16'hDEAD); step(); idle();
    chk("R6 A granted", pa_rdata, 16'h5555);
    chk("R6 B busy", pb_busy, 1);
    chk("R6 B rdata zero", pb_rdata, 0);
    drv_a(0, 0, 3, 4, 0); step();
    chk("R6 B write dropped", pa_rdata, 16'h5555);
    chk("R6 busy clears", pb_busy, 0);
    drv_a(0, 1, 3, 5, 16'h7777); drv_b(0, 0, 3, 5, 0); step(); idle();
    chk("R6 blocked read busy", pb_busy, 1);
    chk("R6 blocked read zero", pb_rdata, 0);
    drv_b(0, 0, 3, 5, 0); step(); idle();
    chk("R6 A write landed", pb_rdata, 16'h7777);
  endtask

  task automatic t_concurrent();
    drv_a(0, 1, 0, 1, 16'h1111); drv_b(0, 1, 1, 1, 16'h2222); step();
    chk("R7 no busy on split writes", pb_busy, 0);
    drv_a(0, 0, 1, 1, 0); drv_b(0, 0, 0, 1, 0); step(); idle();
    chk("R7 A read", pa_rdata, 16'h2222);
    chk("R7 B read", pb_rdata, 16'h1111);
    chk("R7 no busy", pb_busy, 0);
  endtask

  task automatic t_mailbox();
    drv_a(0, 1, 2, 1, 16'h0C0C); step();
    drv_a(1, 1, 2, 1, 16'hBEEF); step(); idle();
    chk("R8 irq to B", pb_irq, 1);
    chk("R8 no irq to A", pa_irq, 0);
    drv_a(0, 0, 2, 1, 0); step(); idle();
    chk("R8 bank untouched", pa_rdata, 16'h0C0C);
    drv_b(1, 0, 0, 0, 0); step(); idle();
    chk("R9 B reads message", pb_rdata, 16'hBEEF);
    chk("R9 B irq cleared", pb_irq, 0);
    drv_b(1, 1, 3, 7, 16'h4242); step(); idle();
    chk("R8 irq to A", pa_irq, 1);
    drv_a(1, 0, 0, 0, 0); step();
    chk("R9 A reads message", pa_rdata, 16'h4242);
    chk("R9 A irq cleared", pa_irq, 0);
    step(); idle();
    chk("R10 message kept", pa_rdata, 16'h4242);
    drv_b(1, 0, 0, 0, 0); step(); idle();
    chk("R10 other direction kept", pb_rdata, 16'hBEEF);
  endtask

  task automatic t_race();
    drv_a(1, 0, 0, 0, 0); drv_b(1, 1, 0, 0, 16'h9999); step(); idle();
    chk("R9 race old data", pa_rdata, 16'h4242);
    chk("R9 race irq kept", pa_irq, 1);
    drv_a(1, 0, 0, 0, 0); step(); idle();
    chk("R9 new data", pa_rdata, 16'h9999);
    chk("R9 irq cleared after", pa_irq, 0);
  endtask

  initial begin
    t_reset();
    t_rw();
    t_banks();
    t_enables();
    t_conflict();
    t_concurrent();
    t_mailbox();
    t_race();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule